// File: doc/BRIEF.md
# Multi-threshold pixel photon counter

This block is the digital counting stage of a single photon-counting pixel. Four discriminator outputs arrive asynchronously, each with its own gate enable. Each one is synchronized and reduced to a single hit per rising edge. A mode input then steers the hits into four saturating counters. The modes are direct one-to-one counting, pile-up counting, and gate-indexed steering. In pile-up counting, the upper discriminators sit above the single-photon energy, so each of them that fires in a pulse adds one extra photon to the first counter.

A snapshot strobe moves all four live counts into shadow storage and restarts the live counters in the same cycle. Counting therefore never pauses while the shadow values are shifted out over a one-bit serial port.

Top module: `pixel_counter_top`

## Requirements
- R1: Each comparator input passes through two synchronizing flops, and a pulse is counted once at its rising edge, however long it stays high.
- R2: A hit on comparator k is discarded while gate_en_i[k] is 0.
- R3: With mode_i = 0, a hit on comparator k increments counter k.
- R4: With mode_i = 1, counter 0 grows in one pulse by the number of gated comparators whose outputs rise; counters 1 to 3 stay unchanged.
- R5: With mode_i = 2 or 3, a hit on comparator 0 increments the counter numbered by gate_idx_i, and hits on comparators 1 to 3 are discarded.
- R6: A counter that would pass 0xFFFF stays at 0xFFFF. Its bit in ovf_o is then set and stays set until reset.
- R7: A snap_i cycle copies all four counters to shadow storage and clears them. An increment in that same cycle lands in the cleared counter, so the counter restarts at that increment rather than at 0.
- R8: After a snapshot, sdo_o presents shadow counter 0 MSB first, followed by counters 1, 2 and 3. Each cycle with shift_en_i high advances one bit, so the readout takes 64 shifts. Without shift_en_i or snap_i, sdo_o holds its value.
- R9: After reset, all counters, shadow bits and ovf_o are zero and sdo_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 4 | Asynchronous comparator outputs |
| gate_en_i | input | 4 | Per-comparator gate, 1 = count |
| mode_i | input | 2 | 0 direct, 1 pile-up, 2/3 steered |
| gate_idx_i | input | 2 | Target counter in steered modes |
| snap_i | input | 1 | Snapshot and clear strobe |
| shift_en_i | input | 1 | Advance serial readout one bit |
| sdo_o | output | 1 | Serial shadow data, MSB first |
| ovf_o | output | 4 | Sticky per-counter saturation flags |

## Verification
Live counters can only be seen through a snapshot. A wrong routing, a missed edge or a bad clear therefore shows up as a wrong 16-bit word in the readout that follows the next snapshot, at the bit position of the corrupted counter. A broken saturation path shows up immediately on ovf_o, and in the readout as a wrapped value. A shift register that moves at the wrong time changes sdo_o between shifts and misaligns every later word of the same readout.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT  = 2'd0,
    MODE_PILEUP  = 2'd1,
    MODE_STEER_A = 2'd2,
    MODE_STEER_B = 2'd3
  } pxc_mode_e;
endpackage

// File: rtl/pxc_edge_sync.sv
module pxc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_i,
  input  logic gate_i,
  output logic hit_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= cmp_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign hit_o = s2_q & ~prev_q & gate_i;
endmodule

// File: rtl/pxc_router.sv
module pxc_router #(
  parameter int N_CMP = 4,
  localparam int INC_W = $clog2(N_CMP + 1),
  localparam int IDX_W = $clog2(N_CMP)
) (
  input  logic [N_CMP-1:0]            hit_i,
  input  logic [1:0]                  mode_i,
  input  logic [IDX_W-1:0]            idx_i,
  output logic [N_CMP-1:0][INC_W-1:0] inc_o
);
  import pxc_pkg::*;

  always_comb begin
    inc_o = '0;
    case (pxc_mode_e'(mode_i))
      MODE_DIRECT: begin
        for (int k = 0; k < N_CMP; k++) inc_o[k] = INC_W'(hit_i[k]);
      end
      MODE_PILEUP: inc_o[0] = INC_W'($countones(hit_i));
      default: begin
        if (hit_i[0]) inc_o[idx_i] = INC_W'(1);
      end
    endcase
  end
endmodule

// File: rtl/pxc_counter.sv
module pxc_counter #(
  parameter int CNT_W = 16,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic [CNT_W:0]   sum;
  logic             sat, cnt_en;

  always_comb begin
    sum    = {1'b0, cnt_q} + {{(CNT_W + 1 - INC_W){1'b0}}, inc_i};
    sat    = sum[CNT_W];
    cnt_en = snap_i | (|inc_i);
    if (snap_i)   cnt_d = CNT_W'(inc_i);
    else if (sat) cnt_d = '1;
    else          cnt_d = sum[CNT_W-1:0];
    ovf_d = ovf_q | (~snap_i & sat);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/pxc_shadow_shift.sv
module pxc_shadow_shift #(
  parameter int N_CMP = 4,
  parameter int CNT_W = 16,
  localparam int SR_W = N_CMP * CNT_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            snap_i,
  input  logic                            shift_en_i,
  input  logic [N_CMP-1:0][CNT_W-1:0]     cnt_i,
  output logic                            sdo_o
);
  logic [SR_W-1:0] sr_q, sr_d;
  logic            sr_en;

  always_comb begin
    sr_en = snap_i | shift_en_i;
    sr_d  = {sr_q[SR_W-2:0], 1'b0};
    if (snap_i) begin
      for (int k = 0; k < N_CMP; k++)
        sr_d[SR_W-1-k*CNT_W -: CNT_W] = cnt_i[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign sdo_o = sr_q[SR_W-1];
endmodule

// File: rtl/pixel_counter_top.sv
module pixel_counter_top #(
  parameter int N_CMP = 4,
  parameter int CNT_W = 16,
  localparam int INC_W = $clog2(N_CMP + 1),
  localparam int IDX_W = $clog2(N_CMP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CMP-1:0] cmp_i,
  input  logic [N_CMP-1:0] gate_en_i,
  input  logic [1:0]       mode_i,
  input  logic [IDX_W-1:0] gate_idx_i,
  input  logic             snap_i,
  input  logic             shift_en_i,
  output logic             sdo_o,
  output logic [N_CMP-1:0] ovf_o
);
  logic [N_CMP-1:0]            hit;
  logic [N_CMP-1:0][INC_W-1:0] inc;
  logic [N_CMP-1:0][CNT_W-1:0] cnt;

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    pxc_edge_sync u_sync (
      .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i[k]),
      .gate_i(gate_en_i[k]), .hit_o(hit[k])
    );
    pxc_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc_i(inc[k]), .snap_i(snap_i),
      .cnt_o(cnt[k]), .ovf_o(ovf_o[k])
    );
  end

  pxc_router #(.N_CMP(N_CMP)) u_router (
    .hit_i(hit), .mode_i(mode_i), .idx_i(gate_idx_i), .inc_o(inc)
  );

  pxc_shadow_shift #(.N_CMP(N_CMP), .CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .snap_i(snap_i), .shift_en_i(shift_en_i),
    .cnt_i(cnt), .sdo_o(sdo_o)
  );
endmodule

// File: rtl/pixel_counter_chk.sv
module pixel_counter_chk #(
  parameter int N_CMP = 4,
  parameter int CNT_W = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N_CMP-1:0]            gate_en_i,
  input logic [1:0]                  mode_i,
  input logic                        snap_i,
  input logic                        shift_en_i,
  input logic                        sdo_o,
  input logic [N_CMP-1:0]            ovf_o,
  input logic [N_CMP-1:0][CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  for (genvar k = 0; k < N_CMP; k++) begin : g_chk
    p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[k] == MAXV && !snap_i) |=> cnt[k] == MAXV);
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o[k] |=> ovf_o[k]);
    p_gate_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd0 && !gate_en_i[k] && !snap_i) |=> $stable(cnt[k]));
    p_snap_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      snap_i |=> cnt[k] <= CNT_W'(N_CMP));
  end

  p_sdo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_i && !shift_en_i) |=> $stable(sdo_o));
endmodule

bind pixel_counter_top pixel_counter_chk #(.N_CMP(N_CMP), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en_i(gate_en_i), .mode_i(mode_i),
  .snap_i(snap_i), .shift_en_i(shift_en_i), .sdo_o(sdo_o),
  .ovf_o(ovf_o), .cnt(cnt)
);

// File: tb/test_pixel_counter_top.sv
`timescale 1ns/1ps
module test_pixel_counter_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cmp, gate;
  logic [1:0] mode, idx;
  logic       snap, shift_en, sdo;
  logic [3:0] ovf;

  int n_run = 0, n_fail = 0;
  int model[4];
  logic [15:0] exp_q[$], got_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #4 clk = ~clk;

  pixel_counter_top i_pixel_counter_top (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp), .gate_en_i(gate), .mode_i(mode),
    .gate_idx_i(idx), .snap_i(snap), .shift_en_i(shift_en), .sdo_o(sdo),
    .ovf_o(ovf)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bump(input int k, input int n);
    model[k] = (model[k] + n > 65535) ? 65535 : model[k] + n;
  endtask

  // model update for one pulse on the comparators in m
  task automatic model_pulse(input logic [3:0] m);
    logic [3:0] h = m & gate;
    case (mode)
      2'd0: for (int k = 0; k < 4; k++) if (h[k]) bump(k, 1);
      2'd1: bump(0, $countones(h));
      default: if (h[0]) bump(idx, 1);
    endcase
  endtask

  task automatic pulse(input logic [3:0] m, input int hi = 2, input int lo = 2);
    cmp = m;
    repeat (hi) @(negedge clk);
    cmp = 4'b0;
    repeat (lo) @(negedge clk);
    model_pulse(m);
  endtask

  // driver: snapshot pushes expected words
  task automatic snapshot(input string req);
    snap = 1'b1;
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back(16'(model[k]));
      tag_q.push_back(req);
      model[k] = 0;
    end
    @(negedge clk);
    snap = 1'b0;
  endtask

  task automatic readout();
    for (int w = 0; w < 4; w++) begin
      logic [15:0] v = '0;
      for (int b = 0; b < 16; b++) begin
        v = {v[14:0], sdo};
        shift_en = 1'b1;
        @(negedge clk);
      end
      shift_en = 1'b0;
      got_q.push_back(v);
    end
  endtask

  // monitor: pops and compares
  always @(negedge clk) begin
    while (got_q.size() > 0 && exp_q.size() > 0)
      check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
  end

  task automatic finish_run();
    @(negedge clk);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 4; k++) model[k] = 0;
    rst_n = 1'b0; cmp = '0; gate = '0; mode = '0; idx = '0;
    snap = 1'b0; shift_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ovf", 16'(ovf), 16'h0);
    check("R9 sdo", 16'(sdo), 16'h0);
    snapshot("R9 reset counts"); readout();

    // R3 direct mode, R1 long pulse counts once
    gate = 4'hF; mode = 2'd0;
    pulse(4'b0001); pulse(4'b0010); pulse(4'b1111);
    pulse(4'b0100, 9, 3); pulse(4'b1000); pulse(4'b1010);
    snapshot("R3/R1 direct"); readout();

    // R2 gating
    gate = 4'b0101;
    repeat (3) pulse(4'b1111);
    pulse(4'b0010);
    snapshot("R2 gate"); readout();

    // R4 pile-up
    gate = 4'hF; mode = 2'd1;
    pulse(4'b0001); pulse(4'b0011); pulse(4'b0111); pulse(4'b1111);
    gate = 4'b1011; pulse(4'b1111);
    snapshot("R4 pileup"); readout();

    // R5 steered modes
    gate = 4'hF; mode = 2'd2;
    for (int i = 0; i < 4; i++) begin
      idx = 2'(i);
      repeat (i + 1) pulse(4'b0001);
      pulse(4'b1110);
    end
    mode = 2'd3; idx = 2'd2; pulse(4'b0011);
    snapshot("R5 steer"); readout();

    // R7 snapshot coincident with an increment
    mode = 2'd0; gate = 4'hF; idx = '0;
    pulse(4'b0100); pulse(4'b0001);
    cmp = 4'b0001;
    @(negedge clk); @(negedge clk);
    snapshot("R7 coincident shadow");
    model[0] = 1;
    cmp = 4'b0000;
    repeat (3) @(negedge clk);
    readout();
    snapshot("R7 fresh counter"); readout();

    // R8 sdo holds without shift
    pulse(4'b0001);
    model[0] = 16'h8000 | model[0];
    snap = 1'b1; @(negedge clk); snap = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 sdo hold", 16'(sdo), 16'h0);
    model[0] = 0;

    // R6 saturation in pile-up mode
    mode = 2'd1; gate = 4'hF;
    check("R6 ovf before", 16'(ovf), 16'h0);
    repeat (16385) pulse(4'b1111);
    check("R6 ovf set", 16'(ovf), 16'h0001);
    snapshot("R6 saturate"); readout();
    repeat (3) @(negedge clk);
    check("R6 ovf sticky", 16'(ovf), 16'h0001);
    check("R8 sdo after readout", 16'(sdo), 16'h0);

    done = 1;
    finish_run();
  end
endmodule